// File: doc/BRIEF.md
# Domain Access Control Checker

This block gives the final verdict on a memory access once address translation has produced the access's domain number and its two access-permission (AP) bits. It holds one control register with a 2-bit mode field for each of 16 domains. Software loads this register through a simple write port. For each access, the block looks up the mode of the addressed domain. The mode decides whether the AP bits are consulted at all:

- A manager domain lets every access through.
- A client domain passes the access to the AP decode.
- A no-access domain, or one left in the reserved code, faults every access.

Each access carries the domain number, the AP bits, a privileged-mode flag and a write flag. The block answers with exactly one of three outputs: allow, domain fault or permission fault. The verdict is registered, so it appears one clock after the request. Translation and exception entry are handled elsewhere.

Top module: `dac_checker`

## Requirements
- R1: After synchronous reset the control register is all zeros. Every domain is therefore in no-access mode, and a request to any domain gets a domain fault. While reset is applied, or when no request was made, rsp_valid and all three verdict outputs are low.
- R2: Mode code 2'b00 (no access) gives a domain fault for every access to that domain, whatever the AP bits, privilege and direction.
- R3: Mode code 2'b10 (reserved) is handled exactly like no access: every access gets a domain fault.
- R4: Mode code 2'b11 (manager) allows every access without looking at the AP bits.
- R5: In mode code 2'b01 (client), AP 2'b00 denies every access with a permission fault.
- R6: In client mode, AP 2'b01 allows privileged reads and writes and denies all user accesses with a permission fault.
- R7: In client mode, AP 2'b10 allows all privileged accesses and user reads, and denies user writes with a permission fault.
- R8: In client mode, AP 2'b11 allows every access.
- R9: The mode of domain n is taken from bits [2n+1:2n] of the control register. Domain 0 uses the least significant pair.
- R10: When rsp_valid is high, exactly one of rsp_allow, rsp_dom_fault and rsp_perm_fault is high. A denied client access never raises a domain fault.
- R11: The verdict for a request sampled at a rising edge appears on the outputs right after that edge. A register write sampled at an edge governs requests from the next edge onward.
- R12: When cfg_we is low, cfg_wdata has no effect on the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the domain mode register |
| cfg_wdata | input | 32 | New register value, 2 bits per domain |
| req_valid | input | 1 | An access is presented this cycle |
| req_domain | input | 4 | Domain number of the access |
| req_ap | input | 2 | Access-permission bits from translation |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Verdict outputs are meaningful |
| rsp_allow | output | 1 | Access may proceed |
| rsp_dom_fault | output | 1 | Access rejected by the domain mode |
| rsp_perm_fault | output | 1 | Access rejected by the AP bits |

## Verification
Every verdict is due one cycle after its request. The bench drives a request at a falling edge and reads the outputs at the next falling edge, half a period after the registering edge. A register write is treated the same way: the bench's model of the register changes only at the edge that samples the write. A request driven in the cycle after the write is therefore checked against the new modes. Random requests and random register contents are mixed with directed sweeps of every mode, every AP code, both privilege levels and both directions. Each result is compared with a model built only from the requirements.

// File: rtl/dac_pkg.sv
package dac_pkg;

  // Per-domain mode codes; the values are fixed by the register layout
  typedef enum logic [1:0] {
    DM_NONE    = 2'b00,
    DM_CLIENT  = 2'b01,
    DM_RSVD    = 2'b10,
    DM_MANAGER = 2'b11
  } dom_mode_e;

  // Client-mode permission codes
  typedef enum logic [1:0] {
    AP_DENY     = 2'b00,
    AP_PRIV_RW  = 2'b01,
    AP_USER_RO  = 2'b10,
    AP_OPEN     = 2'b11
  } ap_code_e;

  typedef struct packed {
    logic allow;
    logic dom_fault;
    logic perm_fault;
  } verdict_t;

endpackage

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= wdata;
    end
  end

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

  // R11
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));

endmodule

// File: rtl/dac_mode_sel.sv
module dac_mode_sel
  import dac_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  parameter int MODE_W      = 2,
  localparam int REG_W      = NUM_DOMAINS * MODE_W,
  localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
  input  logic [REG_W-1:0] ctrl,
  input  logic [DOM_W-1:0] dom,
  output dom_mode_e        mode
);

  logic [MODE_W-1:0] fields [NUM_DOMAINS];

  // Split the register into one mode field per domain
  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
    assign fields[g] = ctrl[g*MODE_W +: MODE_W];
  end

  assign mode = dom_mode_e'(fields[dom]);

endmodule

// File: rtl/dac_ap_check.sv
module dac_ap_check
  import dac_pkg::*;
(
  input  logic [1:0] ap,
  input  logic       priv,
  input  logic       write,
  output logic       ok
);

  always_comb begin
    unique case (ap_code_e'(ap))
      AP_DENY:    ok = 1'b0;
      AP_PRIV_RW: ok = priv;
      AP_USER_RO: ok = priv | ~write;
      AP_OPEN:    ok = 1'b1;
      default:    ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/dac_checker.sv
module dac_checker
  import dac_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  localparam int MODE_W     = 2,
  localparam int REG_W      = NUM_DOMAINS * MODE_W,
  localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic [DOM_W-1:0] req_domain,
  input  logic [1:0]       req_ap,
  input  logic             req_priv,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic             rsp_dom_fault,
  output logic             rsp_perm_fault
);

  logic [REG_W-1:0] ctrl_q;
  dom_mode_e        mode_w;
  logic             ap_ok_w;
  verdict_t         verdict_w;
  verdict_t         verdict_q;

  dac_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (ctrl_q)
  );

  dac_mode_sel #(.NUM_DOMAINS(NUM_DOMAINS), .MODE_W(MODE_W)) u_sel (
    .ctrl (ctrl_q),
    .dom  (req_domain),
    .mode (mode_w)
  );

  dac_ap_check u_ap (
    .ap    (req_ap),
    .priv  (req_priv),
    .write (req_write),
    .ok    (ap_ok_w)
  );

  // The domain mode decides first; the AP bits matter only for clients
  always_comb begin
    verdict_w = '0;
    unique case (mode_w)
      DM_MANAGER: verdict_w.allow = 1'b1;
      DM_CLIENT: begin
        verdict_w.allow      = ap_ok_w;
        verdict_w.perm_fault = ~ap_ok_w;
      end
      default: verdict_w.dom_fault = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      verdict_q <= '0;
    end else begin
      rsp_valid <= req_valid;
      verdict_q <= req_valid ? verdict_w : '0;
    end
  end

  assign rsp_allow      = verdict_q.allow;
  assign rsp_dom_fault  = verdict_q.dom_fault;
  assign rsp_perm_fault = verdict_q.perm_fault;

  // R10
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_allow, rsp_dom_fault, rsp_perm_fault}) == 1));

  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_allow || rsp_dom_fault || rsp_perm_fault));

  // R2
  no_access_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_w == DM_NONE) |=> rsp_dom_fault);

  // R3
  reserved_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_w == DM_RSVD) |=> rsp_dom_fault);

  // R4
  manager_allow_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_w == DM_MANAGER) |=> rsp_allow);

  // R5
  client_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_w == DM_CLIENT && req_ap == 2'b00) |=> rsp_perm_fault);

  // R10
  client_no_dom_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_w == DM_CLIENT) |=> !rsp_dom_fault);

endmodule

// File: tb/dac_checker_bench.sv
`timescale 1ns/1ps
module dac_checker_bench;

  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [3:0]  req_domain;
  logic [1:0]  req_ap;
  logic        req_priv;
  logic        req_write;
  logic        rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_reg;

  always #2.5 clk = ~clk;

  dac_checker u_dac_checker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_domain(req_domain), .req_ap(req_ap),
    .req_priv(req_priv), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_dom_fault(rsp_dom_fault), .rsp_perm_fault(rsp_perm_fault)
  );

  // Expected {allow, dom_fault, perm_fault} from the requirements
  function automatic logic [2:0] expect_verdict(input logic [31:0] r, input logic [3:0] d,
                                                input logic [1:0] ap, input logic pv,
                                                input logic wr);
    logic [1:0] m;
    logic ok;
    m = r[2*d +: 2];
    if (m == 2'b11) return 3'b100;            // R4
    if (m != 2'b01) return 3'b010;            // R2 / R3
    case (ap)                                 // R5..R8
      2'b00:   ok = 1'b0;
      2'b01:   ok = pv;
      2'b10:   ok = pv || !wr;
      default: ok = 1'b1;
    endcase
    return ok ? 3'b100 : 3'b001;
  endfunction

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = ~v;
    model_reg = v;
  endtask

  task automatic probe(input string tag, input logic [3:0] d, input logic [1:0] ap,
                       input logic pv, input logic wr);
    logic [2:0] exp_v;
    logic [3:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_domain = d; req_ap = ap; req_priv = pv; req_write = wr;
    exp_v = expect_verdict(model_reg, d, ap, pv, wr);
    @(negedge clk);
    req_valid = 1'b0;
    got = {rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault};
    checks++;
    if (got !== {1'b1, exp_v}) begin
      errors++;
      $display("FAIL %s: dom=%0d ap=%b priv=%b wr=%b actual=%b expected=%b",
               tag, d, ap, pv, wr, got, {1'b1, exp_v});
    end
  endtask

  task automatic sweep(input string tag, input logic [3:0] d);
    for (int k = 0; k < 16; k++) probe(tag, d, k[3:2], k[1], k[0]);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0a11));
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '1; req_valid = 1'b1;
    req_domain = '0; req_ap = 2'b11; req_priv = 1'b1; req_write = 1'b0;
    model_reg = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held low during reset even with a request present
    checks++;
    if ({rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b expected=0000",
               {rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault});
    end
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 idle outputs: actual=%b expected=0000",
               {rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault});
    end
    // R1: every domain is no-access after reset
    for (int d = 0; d < 16; d++) probe("R1 reset mode", d[3:0], 2'b11, 1'b1, 1'b0);

    // R2, R3, R4 per-mode sweeps; R9 field placement via distinct neighbours
    write_reg(32'h0000_00E4);           // dom0=00 dom1=01 dom2=10 dom3=11
    sweep("R2 no access", 4'd0);
    sweep("R3 reserved", 4'd2);
    sweep("R4 manager", 4'd3);
    sweep("R5 R6 R7 R8 client AP", 4'd1);
    write_reg(32'h4000_0003);           // dom15=01, dom0=11, rest 00
    probe("R9 top field", 4'd15, 2'b01, 1'b0, 1'b0);
    probe("R9 low field", 4'd0, 2'b00, 1'b0, 1'b1);
    probe("R9 unset field", 4'd14, 2'b11, 1'b1, 1'b0);

    // R11: write followed at once by a request sees the new mode
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 32'h0;
    model_reg = 32'hFFFF_FFFF;
    probe("R11 write then request", 4'd7, 2'b00, 1'b0, 1'b1);

    // R12: data without strobe is ignored
    @(negedge clk); cfg_wdata = 32'h0000_0000;
    @(negedge clk); cfg_wdata = 32'h5555_5555;
    probe("R12 no strobe", 4'd7, 2'b00, 1'b0, 1'b1);
    probe("R12 no strobe", 4'd12, 2'b00, 1'b0, 1'b0);

    // R10 and all above: random registers and requests
    for (int i = 0; i < 3000; i++) begin
      if ((i % 25) == 0) begin
        v = $urandom;
        write_reg(v);
      end
      v = $urandom;
      probe("R10 random", v[3:0], v[5:4], v[6], v[7]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule